// File: doc/BRIEF.md
# CAN Bit Stuffing and Destuffing Layer

This block sits between a frame serializer/deserializer and the bus bit sampler of a CAN node. It handles one bit for each bit-time strobe. In the transmit direction it takes the NRZ bit stream from the serializer. After a run of identical bits it inserts a bit of the opposite level. While that bit goes out, it lowers a ready line so the serializer holds its next bit. In the receive direction it drops those inserted bits from the sampled bus stream. It raises a one-cycle error pulse when a run grows one bit longer than the stuffing rule allows. Six dominant bits in a row, such as an error flag from another node, therefore show up as a stuff error.

A single run tracker holds the current run length and level, and a direction input selects which stream it follows. In transmit it follows the emitted bus bits. In receive it follows the sampled bus bits. Three inputs frame the work:

- A frame-start pulse, given with the start-of-frame bit, restarts the run count.
- A frame-stop pulse, given with the last bit of a frame, returns the block to pass-through.
- A stuffing-enable level is high from the start-of-frame bit through the last CRC bit.

Logic 0 is dominant and logic 1 is recessive.

The control state machine has three states:

- IDLE: outside a frame. Bits pass straight through.
- RUN: inside a frame. Stuffing and destuffing apply.
- ERR: after a receive stuff error. Data is withheld.

Its transitions are evaluated only on a strobe:

- START: any state goes to RUN on frame-start. This has the highest priority.
- STOP: RUN or ERR goes to IDLE on frame-stop.
- VIOLATE: RUN goes to ERR on a receive stuff error.
- HOLD: in all other cases the state is kept.

Top module: `csd_codec`

## Requirements
- R1: After reset, tx_out is 1 (recessive), tx_ready is 1, and rx_valid and rx_err are 0.
- R2: Outputs change only on the clock edge where bit_stb is 1. tx_out holds its value between strobes, and rx_valid and rx_err are single-cycle pulses following a strobe.
- R3: In transmit with stuffing enabled in RUN, once RUN_LEN (5) identical bits have been emitted, the next strobe emits the complement of that level and tx_in is ignored.
- R4: tx_ready is 0 from the strobe that completes a run of RUN_LEN until the strobe that emits the stuff bit, which is one bit time. tx_ready returns to 1 after that strobe.
- R5: An inserted or removed stuff bit counts as the first bit of the next run. For example, a stuff bit 1 followed by four data 1s forms a new full run.
- R6: In receive with stuffing enabled in RUN, the bit after a run of RUN_LEN that has the opposite level is discarded: no rx_valid pulse is given for it.
- R7: In receive, a bit after a run of RUN_LEN that has the same level gives an rx_err pulse and no rx_valid, and enters ERR. ERR gives no rx_valid until frame_stop or frame_start.
- R8: With stuff_en at 0, no bit is inserted, none is discarded and no error is raised, even for runs longer than RUN_LEN.
- R9: frame_start restarts the run, so the start-of-frame bit counts as the first bit of a run whatever came before.
- R10: After frame_stop the block is in IDLE: every strobe passes tx_in to tx_out with tx_ready at 1, and every receive strobe gives rx_valid.
- R11: In transmit (dir_tx=1), rx_valid and rx_err stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_stb | input | 1 | One-cycle strobe, once per bit time |
| frame_start | input | 1 | Marks the start-of-frame bit (with bit_stb) |
| frame_stop | input | 1 | Marks the last bit of a frame (with bit_stb) |
| stuff_en | input | 1 | Stuffing region active for this bit |
| dir_tx | input | 1 | 1: transmit direction, 0: receive direction |
| tx_in | input | 1 | Next bit from the serializer |
| tx_ready | output | 1 | tx_in is consumed at the next strobe |
| tx_out | output | 1 | Bit driven toward the bus |
| rx_in | input | 1 | Sampled bus bit |
| rx_valid | output | 1 | Pulse: rx_data holds a destuffed data bit |
| rx_data | output | 1 | Received data bit |
| rx_err | output | 1 | Pulse: stuff rule violated |

## Verification
The assertions check rules that hold on every cycle:

- The outputs move only on a strobe.
- A low tx_ready never lasts past one strobe.
- The bit emitted while tx_ready is low is the complement of the previous bit.
- An error pulse never coincides with a data pulse.
- The receive pulses stay silent in transmit.

Only the directed scenarios can show the run lengths at which stuffing, discarding and errors occur. The same holds for a stuff bit starting the next run, for frame-start restarting the count, and for the ERR and IDLE pass-through behaviour after a violation or a stop.

// File: rtl/csd_pkg.sv
`timescale 1ns/1ps
package csd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_ERR  = 2'd2
    } csd_state_e;

    localparam logic LVL_DOM = 1'b0;
    localparam logic LVL_REC = 1'b1;
endpackage

// File: rtl/csd_run_tracker.sv
`timescale 1ns/1ps
module csd_run_tracker #(
    parameter int RUN_LEN = 5,
    parameter int CW      = $clog2(RUN_LEN + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    input  logic          fresh,
    input  logic          bit_in,
    output logic [CW-1:0] run_cnt,
    output logic          run_lvl
);
    localparam logic [CW-1:0] CNT_MAX = CW'(RUN_LEN);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cnt <= '0;
            run_lvl <= csd_pkg::LVL_REC;
        end else if (adv) begin
            run_lvl <= bit_in;
            if (fresh || (bit_in != run_lvl) || (run_cnt == '0))
                run_cnt <= CW'(1);
            else if (run_cnt != CNT_MAX)
                run_cnt <= run_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/csd_stuff_judge.sv
`timescale 1ns/1ps
module csd_stuff_judge #(
    parameter int RUN_LEN = 5,
    parameter int CW      = $clog2(RUN_LEN + 1)
) (
    input  logic          in_run,
    input  logic          stuff_en,
    input  logic          fresh,
    input  logic [CW-1:0] run_cnt,
    input  logic          run_lvl,
    input  logic          rx_bit,
    output logic          run_full,
    output logic          slot,
    output logic          rx_bad,
    output logic          stuff_val
);
    localparam logic [CW-1:0] CNT_MAX = CW'(RUN_LEN);

    always_comb begin
        run_full  = in_run && stuff_en && (run_cnt == CNT_MAX);
        slot      = run_full && !fresh;
        rx_bad    = slot && (rx_bit == run_lvl);
        stuff_val = ~run_lvl;
    end
endmodule

// File: rtl/csd_codec.sv
`timescale 1ns/1ps
module csd_codec #(
    parameter int RUN_LEN = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_stb,
    input  logic frame_start,
    input  logic frame_stop,
    input  logic stuff_en,
    input  logic dir_tx,
    input  logic tx_in,
    output logic tx_ready,
    output logic tx_out,
    input  logic rx_in,
    output logic rx_valid,
    output logic rx_data,
    output logic rx_err
);
    import csd_pkg::*;

    localparam int CW = $clog2(RUN_LEN + 1);

    csd_state_e    state_q, state_d;
    logic [CW-1:0] run_cnt;
    logic          run_lvl;
    logic          fresh, in_run, in_err;
    logic          run_full, slot, rx_bad, stuff_val;
    logic          emit_bit, trk_bit;

    assign fresh    = bit_stb && frame_start;
    assign in_run   = (state_q == ST_RUN);
    assign in_err   = (state_q == ST_ERR) && !fresh;
    assign emit_bit = slot ? stuff_val : tx_in;
    assign trk_bit  = dir_tx ? emit_bit : rx_in;

    csd_run_tracker #(.RUN_LEN(RUN_LEN), .CW(CW)) u_trk (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (bit_stb),
        .fresh   (fresh),
        .bit_in  (trk_bit),
        .run_cnt (run_cnt),
        .run_lvl (run_lvl)
    );

    csd_stuff_judge #(.RUN_LEN(RUN_LEN), .CW(CW)) u_judge (
        .in_run    (in_run),
        .stuff_en  (stuff_en),
        .fresh     (fresh),
        .run_cnt   (run_cnt),
        .run_lvl   (run_lvl),
        .rx_bit    (rx_in),
        .run_full  (run_full),
        .slot      (slot),
        .rx_bad    (rx_bad),
        .stuff_val (stuff_val)
    );

    // Next-state logic: START has priority, then STOP, then VIOLATE.
    always_comb begin
        state_d = state_q;
        if (bit_stb) begin
            if (frame_start) begin
                state_d = ST_RUN;
            end else begin
                unique case (state_q)
                    ST_IDLE: state_d = ST_IDLE;
                    ST_RUN: begin
                        if (frame_stop)
                            state_d = ST_IDLE;
                        else if (!dir_tx && rx_bad)
                            state_d = ST_ERR;
                    end
                    ST_ERR: begin
                        if (frame_stop)
                            state_d = ST_IDLE;
                    end
                    default: state_d = ST_IDLE;
                endcase
            end
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_out   <= LVL_REC;
            rx_valid <= 1'b0;
            rx_data  <= LVL_REC;
            rx_err   <= 1'b0;
        end else if (bit_stb) begin
            tx_out   <= emit_bit;
            rx_data  <= rx_in;
            rx_valid <= !dir_tx && !in_err && !slot;
            rx_err   <= !dir_tx && rx_bad;
        end else begin
            rx_valid <= 1'b0;
            rx_err   <= 1'b0;
        end
    end

    assign tx_ready = !run_full;
endmodule

// File: rtl/csd_checker.sv
`timescale 1ns/1ps
module csd_checker (
    input logic clk,
    input logic rst_n,
    input logic bit_stb,
    input logic frame_start,
    input logic dir_tx,
    input logic tx_ready,
    input logic tx_out,
    input logic rx_valid,
    input logic rx_err
);
    // R2: tx_out only moves on a strobe
    assert_hold_between_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_stb |=> $stable(tx_out));

    // R2: receive pulses only follow a strobe
    assert_pulse_after_stb_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid || rx_err) |-> $past(bit_stb));

    // R4: a stall lasts a single bit time
    assert_stall_one_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_stb && !tx_ready) |=> tx_ready);

    // R3: the bit emitted during a stall is the complement of the run level
    assert_stuff_complement_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_stb && !tx_ready && dir_tx && !frame_start) |=> (tx_out != $past(tx_out)));

    // R7: an error pulse never carries data
    assert_err_no_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_err |-> !rx_valid);

    // R11: receive pulses are silent in transmit
    assert_tx_quiet_rx_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid || rx_err) |-> !$past(dir_tx));
endmodule

bind csd_codec csd_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_stb     (bit_stb),
    .frame_start (frame_start),
    .dir_tx      (dir_tx),
    .tx_ready    (tx_ready),
    .tx_out      (tx_out),
    .rx_valid    (rx_valid),
    .rx_err      (rx_err)
);

// File: tb/sim_csd_codec.sv
`timescale 1ns/1ps
module sim_csd_codec;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_stb = 1'b0, frame_start = 1'b0, frame_stop = 1'b0;
    logic stuff_en = 1'b1, dir_tx = 1'b1, tx_in = 1'b1, rx_in = 1'b1;
    logic tx_ready, tx_out, rx_valid, rx_data, rx_err;

    int n_tests = 0;
    int n_fail  = 0;

    logic g_txo, g_rdy, g_val, g_dat, g_err;

    always #10 clk = ~clk;

    csd_codec u0 (
        .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .frame_start(frame_start),
        .frame_stop(frame_stop), .stuff_en(stuff_en), .dir_tx(dir_tx),
        .tx_in(tx_in), .tx_ready(tx_ready), .tx_out(tx_out), .rx_in(rx_in),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_err(rx_err)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_eq(input string tag, input logic act, input logic exp);
        chk(act === exp, tag, int'(act), int'(exp));
    endtask

    // One bit time: drive, strobe, sample just after the strobe edge, check hold.
    task automatic step(input logic tb, input logic rb, input logic st, input logic sp);
        @(negedge clk);
        tx_in = tb; rx_in = rb; frame_start = st; frame_stop = sp; bit_stb = 1'b1;
        @(negedge clk);
        bit_stb = 1'b0; frame_start = 1'b0; frame_stop = 1'b0;
        g_txo = tx_out; g_rdy = tx_ready; g_val = rx_valid; g_dat = rx_data; g_err = rx_err;
        @(negedge clk);
        chk_eq("R2 tx_out held", tx_out, g_txo);
        chk_eq("R2 rx_valid pulse", rx_valid, 1'b0);
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk_eq("R1 tx_out", tx_out, 1'b1);
        chk_eq("R1 tx_ready", tx_ready, 1'b1);
        chk_eq("R1 rx_valid", rx_valid, 1'b0);
        chk_eq("R1 rx_err", rx_err, 1'b0);
    endtask

    task automatic t_tx_stuff();
        dir_tx = 1'b1; stuff_en = 1'b1;
        step(0, 1, 1, 0);
        chk_eq("R3 sof out", g_txo, 1'b0);
        chk_eq("R11 no rx_valid", g_val, 1'b0);
        for (int i = 0; i < 4; i++) begin
            step(0, 1, 0, 0);
            chk_eq("R3 data out", g_txo, 1'b0);
            chk_eq("R4 ready", g_rdy, (i == 3) ? 1'b0 : 1'b1);
            chk_eq("R11 no rx_err", g_err, 1'b0);
        end
        step(0, 1, 0, 0);
        chk_eq("R3 stuff bit 1", g_txo, 1'b1);
        chk_eq("R4 ready back", g_rdy, 1'b1);
        for (int i = 0; i < 4; i++) begin
            step(1, 1, 0, 0);
            chk_eq("R5 ready", g_rdy, (i == 3) ? 1'b0 : 1'b1);
        end
        step(1, 1, 0, 0);
        chk_eq("R5 stuff bit 0", g_txo, 1'b0);
        chk_eq("R5 ready back", g_rdy, 1'b1);
        step(1, 1, 0, 1);
        chk_eq("R10 stop bit out", g_txo, 1'b1);
    endtask

    task automatic t_tx_idle();
        dir_tx = 1'b1; stuff_en = 1'b1;
        for (int i = 0; i < 7; i++) begin
            step(0, 1, 0, 0);
            chk_eq("R10 idle pass", g_txo, 1'b0);
            chk_eq("R10 idle ready", g_rdy, 1'b1);
        end
    endtask

    task automatic t_tx_restart();
        dir_tx = 1'b1; stuff_en = 1'b1;
        step(0, 1, 1, 0);
        for (int i = 0; i < 3; i++) step(0, 1, 0, 0);
        step(0, 1, 1, 0);
        chk_eq("R9 restart ready", g_rdy, 1'b1);
        for (int i = 0; i < 3; i++) begin
            step(0, 1, 0, 0);
            chk_eq("R9 no early stall", g_rdy, 1'b1);
            chk_eq("R9 data out", g_txo, 1'b0);
        end
        step(0, 1, 0, 0);
        chk_eq("R9 stall at fifth", g_rdy, 1'b0);
        step(0, 1, 0, 1);
        chk_eq("R3 stuff before stop", g_txo, 1'b1);
    endtask

    task automatic t_tx_noen();
        dir_tx = 1'b1; stuff_en = 1'b0;
        step(0, 1, 1, 0);
        for (int i = 0; i < 7; i++) begin
            step(0, 1, 0, 0);
            chk_eq("R8 tx no stuff", g_txo, 1'b0);
            chk_eq("R8 tx ready", g_rdy, 1'b1);
        end
        step(0, 1, 0, 1);
        stuff_en = 1'b1;
    endtask

    task automatic t_rx_destuff();
        dir_tx = 1'b0; stuff_en = 1'b1;
        step(1, 0, 1, 0);
        chk_eq("R6 sof valid", g_val, 1'b1);
        chk_eq("R6 sof data", g_dat, 1'b0);
        for (int i = 0; i < 4; i++) begin
            step(1, 0, 0, 0);
            chk_eq("R6 data valid", g_val, 1'b1);
        end
        step(1, 1, 0, 0);
        chk_eq("R6 stuff dropped", g_val, 1'b0);
        chk_eq("R6 no error", g_err, 1'b0);
        for (int i = 0; i < 4; i++) begin
            step(1, 1, 0, 0);
            chk_eq("R5 rx data valid", g_val, 1'b1);
            chk_eq("R5 rx data", g_dat, 1'b1);
        end
        step(1, 0, 0, 0);
        chk_eq("R5 rx stuff 0 dropped", g_val, 1'b0);
        chk_eq("R5 rx no error", g_err, 1'b0);
        step(1, 0, 0, 1);
        chk_eq("R6 after stuff valid", g_val, 1'b1);
    endtask

    task automatic t_rx_error();
        dir_tx = 1'b0; stuff_en = 1'b1;
        step(1, 0, 1, 0);
        for (int i = 0; i < 4; i++) step(1, 0, 0, 0);
        step(1, 0, 0, 0);
        chk_eq("R7 error pulse", g_err, 1'b1);
        chk_eq("R7 no data", g_val, 1'b0);
        step(1, 1, 0, 0);
        chk_eq("R7 err state silent", g_val, 1'b0);
        chk_eq("R7 err single", g_err, 1'b0);
        step(1, 1, 0, 1);
        chk_eq("R7 silent on stop", g_val, 1'b0);
        step(1, 0, 0, 0);
        chk_eq("R10 idle rx valid", g_val, 1'b1);
        chk_eq("R10 idle rx data", g_dat, 1'b0);
        chk_eq("R10 idle no err", g_err, 1'b0);
    endtask

    task automatic t_rx_noen();
        dir_tx = 1'b0; stuff_en = 1'b0;
        step(1, 0, 1, 0);
        for (int i = 0; i < 7; i++) begin
            step(1, 0, 0, 0);
            chk_eq("R8 rx valid", g_val, 1'b1);
            chk_eq("R8 rx no err", g_err, 1'b0);
        end
        step(1, 1, 0, 1);
        stuff_en = 1'b1;
    endtask

    initial begin
        #(20 * 200000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_tx_stuff();
        t_tx_idle();
        t_tx_restart();
        t_tx_noen();
        t_rx_destuff();
        t_rx_error();
        t_rx_noen();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule